// File: doc/BRIEF.md
# Conflict-Filled Instruction Cache

This block is a small two-way set-associative store for instruction words, placed beside a program-memory bus. The same bus carries both instruction fetches and data accesses. The cache does not fill on every miss. An entry is only created when a data access and an instruction fetch want the bus in the same cycle.

In such a conflict cycle, a fetch that misses raises a one-cycle stall. The block then remembers the fetch address, which is the instruction two slots past the one that issued the data access. The next word on the memory-return port is written into the least-recently-used way of that address's set. From then on, later fetches of that address hit. They get their instruction from the cache in the same cycle, so a concurrent data access no longer stalls them.

The set index is taken straight from the low four address bits, with no hashing. The tag is the remaining upper bits. A disable input turns the cache into a pass-through that always misses and never fills.

Top module: `cict_cache`

## Requirements
- R1: A synchronous active-high reset invalidates every entry and drops any pending fill, so the first fetch after reset misses.
- R2: A fetch that misses with `pm_data_req` low raises no stall and allocates nothing. The same address fetched again still misses.
- R3: A conflict is `fetch_valid` and `pm_data_req` high in the same cycle. A conflict whose fetch misses drives `fetch_stall` high in that cycle only.
- R4: After a conflict miss, the next `mem_valid` cycle writes `mem_data` as the entry for the conflict's fetch address. A later fetch of that address has `fetch_hit` high and `fetch_instr` equal to that word in the same cycle. It has no stall, even with `pm_data_req` high.
- R5: The set is `fetch_addr[3:0]` and the tag is `fetch_addr[AW-1:4]`. Two addresses that differ only in tag share a set and can both be resident. Consecutive addresses fall in different sets.
- R6: Each set has two ways. A third allocation into a set evicts the entry that was used least recently.
- R7: A hit marks its way as most recently used. In a set where both entries are resident, the entry that hit most recently survives the next allocation into that set.
- R8: While `cache_disable` is high, every lookup misses, no pending fill is recorded, and a return on the memory port writes nothing. A conflict still stalls.
- R9: A `mem_valid` pulse with no pending fill changes no entry.
- R10: When a second conflict miss happens before the return arrives, the newer fetch address replaces the pending one. The older address stays uncached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cache_disable | input | 1 | Forces misses and blocks allocation |
| fetch_valid | input | 1 | Instruction fetch request this cycle |
| fetch_addr | input | AW | Fetch address |
| pm_data_req | input | 1 | Data access on the program-memory bus this cycle |
| mem_valid | input | 1 | Memory return valid; the return arrives in a cycle with no fetch |
| mem_data | input | DW | Returned instruction word |
| fetch_hit | output | 1 | Fetch found in the cache |
| fetch_instr | output | DW | Cached instruction, zero on miss |
| fetch_stall | output | 1 | Conflict miss stall |

## Verification
A wrong LRU bit does not show at first. It only appears after a later allocation into the same set, when a fetch that should hit misses, or the reverse. The bench therefore reuses a small pool of sets and tags, so that evictions happen within a few dozen cycles. A stuck or lost pending-fill address shows up on the first fetch after the following return: the expected hit is missing, or an address that was never filled hits. A wrong index or tag split shows up the first time two addresses with the same tag but different sets are both fetched.

// File: rtl/cict_cache.sv
module cict_cache #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cache_disable,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          pm_data_req,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  output logic          fetch_hit,
  output logic [DW-1:0] fetch_instr,
  output logic          fetch_stall
);
  localparam int IW   = 4;
  localparam int SETS = 1 << IW;
  localparam int TW   = AW - IW;

  logic [TW-1:0]   tag0 [SETS];
  logic [TW-1:0]   tag1 [SETS];
  logic [DW-1:0]   dat0 [SETS];
  logic [DW-1:0]   dat1 [SETS];
  logic [SETS-1:0] v0, v1, lru;
  logic            pend;
  logic [AW-1:0]   paddr;

  wire [IW-1:0] s  = fetch_addr[IW-1:0];
  wire [TW-1:0] t  = fetch_addr[AW-1:IW];
  wire          h0 = fetch_valid & ~cache_disable & v0[s] & (tag0[s] == t);
  wire          h1 = fetch_valid & ~cache_disable & v1[s] & (tag1[s] == t);

  assign fetch_hit   = h0 | h1;
  assign fetch_instr = h1 ? dat1[s] : (h0 ? dat0[s] : '0);
  assign fetch_stall = fetch_valid & pm_data_req & ~fetch_hit;

  wire [IW-1:0] ps   = paddr[IW-1:0];
  wire [TW-1:0] pt   = paddr[AW-1:IW];
  wire          fill = mem_valid & pend & ~cache_disable;
  wire          fw   = lru[ps];

  always_ff @(posedge clk) begin
    if (rst) begin
      v0    <= '0;
      v1    <= '0;
      lru   <= '0;
      pend  <= 1'b0;
      paddr <= '0;
    end else begin
      if (fetch_hit) lru[s] <= h0;
      if (fill) begin
        if (fw) v1[ps] <= 1'b1;
        else    v0[ps] <= 1'b1;
        lru[ps] <= ~fw;
      end
      if (fetch_stall && !cache_disable) begin
        pend  <= 1'b1;
        paddr <= fetch_addr;
      end else if (fill) begin
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      if (fw) begin
        tag1[ps] <= pt;
        dat1[ps] <= mem_data;
      end else begin
        tag0[ps] <= pt;
        dat0[ps] <= mem_data;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fetch_hit);

  // R2
  fill_only_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && pend && !cache_disable) |=> ($stable(v0) && $stable(v1)));

  // R3
  pend_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(fetch_stall && !cache_disable));

  // R4
  stall_records_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_stall && !cache_disable) |=> pend);

  // R8
  off_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    cache_disable |=> ($stable(v0) && $stable(v1)));
endmodule

// File: tb/cict_cache_test.sv
module cict_cache_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0, rst = 1'b1, off = 1'b0, fv = 1'b0, pm = 1'b0, mv = 1'b0;
  logic [AW-1:0] fa = '0;
  logic [DW-1:0] md = '0;
  logic hit, stall;
  logic [DW-1:0] instr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cict_cache #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .cache_disable(off), .fetch_valid(fv), .fetch_addr(fa),
    .pm_data_req(pm), .mem_valid(mv), .mem_data(md),
    .fetch_hit(hit), .fetch_instr(instr), .fetch_stall(stall));

  logic [11:0] mt [2][16];
  logic [DW-1:0] mdat [2][16];
  logic mvld [2][16];
  logic mlru [16];
  logic mpend;
  logic [AW-1:0] mpaddr;

  function automatic void model_reset();
    for (int s = 0; s < 16; s++) begin
      mvld[0][s] = 0; mvld[1][s] = 0; mlru[s] = 0;
    end
    mpend = 0; mpaddr = '0;
  endfunction

  function automatic logic way_hit(int w, logic [AW-1:0] a, logic v, logic o);
    return v && !o && mvld[w][a[3:0]] && mt[w][a[3:0]] == a[15:4];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [AW-1:0] a, logic p,
                      logic m, logic [DW-1:0] d, logic o);
    logic h0, h1, eh, es, fl, fw;
    logic [DW-1:0] ei;
    logic [3:0] s, ps;
    @(negedge clk);
    fv = v; fa = a; pm = p; mv = m; md = d; off = o;
    #1;
    s  = a[3:0];
    h0 = way_hit(0, a, v, o);
    h1 = way_hit(1, a, v, o);
    eh = h0 | h1;
    ei = h1 ? mdat[1][s] : (h0 ? mdat[0][s] : '0);
    es = v && p && !eh;
    check({tag, " hit"}, hit, eh);
    check({tag, " stall"}, stall, es);
    check({tag, " instr"}, instr, ei);
    @(posedge clk);
    ps = mpaddr[3:0];
    fl = m && mpend && !o;
    fw = mlru[ps];
    if (eh) mlru[s] = h0;
    if (fl) begin
      mvld[fw][ps] = 1; mt[fw][ps] = mpaddr[15:4]; mdat[fw][ps] = d;
      mlru[ps] = ~fw;
    end
    if (es && !o) begin mpend = 1; mpaddr = a; end
    else if (fl) mpend = 0;
  endtask

  task automatic fetch(string tag, logic [AW-1:0] a, logic exp_hit);
    step(tag, 1, a, 0, 0, '0, 0);
    check({tag, " direct"}, hit, exp_hit);
  endtask

  task automatic conflict(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
    step(tag, 1, a, 1, 0, '0, 0);
    check({tag, " direct stall"}, stall, 1'b1);
    step(tag, 0, '0, 0, 1, d, 0);
  endtask

  initial begin
    void'($urandom(32'd4721));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    fetch("R1 first fetch", 16'h0103, 0);
    fetch("R2 plain miss", 16'h0103, 0);
    fetch("R2 still miss", 16'h0103, 0);
    check("R2 no stall", stall, 0);
    conflict("R3 conflict miss", 16'h0103, 32'hAAAA0103);
    step("R3 stall cleared", 0, '0, 0, 0, '0, 0);
    check("R3 stall one cycle", stall, 0);
    step("R4 hit under access", 1, 16'h0103, 1, 0, '0, 0);
    check("R4 hit", hit, 1);
    check("R4 instr", instr, 32'hAAAA0103);
    check("R4 no stall", stall, 0);
    fetch("R5 next set", 16'h0104, 0);
    conflict("R5 same set", 16'h0203, 32'hBBBB0203);
    fetch("R5 first stays", 16'h0103, 1);
    fetch("R5 second", 16'h0203, 1);
    conflict("R6 third alloc", 16'h0213, 32'hCCCC0213);
    fetch("R6 lru evicted", 16'h0103, 0);
    fetch("R6 new entry", 16'h0213, 1);
    fetch("R7 touch", 16'h0203, 1);
    conflict("R7 alloc", 16'h0303, 32'hDDDD0303);
    fetch("R7 recent kept", 16'h0203, 1);
    fetch("R7 older gone", 16'h0213, 0);
    step("R9 stray return", 0, '0, 0, 1, 32'hEEEE0000, 0);
    fetch("R9 unchanged a", 16'h0303, 1);
    fetch("R9 unchanged b", 16'h0203, 1);
    fetch("R9 no new", 16'h0000, 0);
    step("R10 first", 1, 16'h0105, 1, 0, '0, 0);
    step("R10 second", 1, 16'h0106, 1, 0, '0, 0);
    step("R10 return", 0, '0, 0, 1, 32'h12340106, 0);
    fetch("R10 newer cached", 16'h0106, 1);
    fetch("R10 older not", 16'h0105, 0);
    step("R8 off miss", 1, 16'h0203, 0, 0, '0, 1);
    check("R8 forced miss", hit, 0);
    step("R8 off conflict", 1, 16'h0107, 1, 0, '0, 1);
    check("R8 stall", stall, 1);
    step("R8 off return", 0, '0, 0, 1, 32'h55550107, 1);
    fetch("R8 no alloc", 16'h0107, 0);
    fetch("R8 back on", 16'h0203, 1);
    step("R1 reset", 0, '0, 0, 0, '0, 0);
    rst = 1;
    @(posedge clk);
    model_reset();
    @(negedge clk); rst = 0;
    fetch("R1 after reset", 16'h0203, 0);
    for (int i = 0; i < 3000; i++) begin
      logic v, p, m, o;
      logic [AW-1:0] a;
      v = ($urandom % 4) != 0;
      a = {10'd0, 2'($urandom % 4), 2'd0, 2'($urandom % 4)};
      p = ($urandom % 3) == 0;
      m = !v && ($urandom % 2);
      o = ($urandom % 16) == 0;
      step("R4/R6/R7 random", v, a, p, m, $urandom, o);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule